// File: doc/BRIEF.md
# Locked Atomic Read-Modify-Write Sequencer

This block sits between a core's load/store path and a shared 64-bit memory bus. It performs one locked read-modify-write at a time: exchange or add, on an operand of 1, 2, 4 or 8 bytes at any byte address. A request is accepted with a ready/valid handshake. The block then waits until every earlier ordinary load and store has finished. Loads to write-combining memory are the one exception and are not waited for. It then holds the bus lock while it reads the operand, computes the new value and writes it back. A misaligned operand takes two beats in each direction.

While the lock is held, the block still grants the bus to instruction-fetch and page-table-walk requests from a second requester port. Ordinary data loads and stores on that port are stalled until the locked sequence is over. When the sequence finishes, the block drops the lock and returns the operand's previous value with a one-cycle completion pulse.

Top module: `atomic_lock_seq`

## Requirements
- R1: `req_ready` is high only while no locked operation is in progress. A request is taken when `req_valid` and `req_ready` are both high. While an operation is in progress, `req_ready` stays low.
- R2: No locked bus beat is issued while any slot has `slot_busy` set with `slot_wc_load` clear. Slots marked as write-combining loads do not delay the sequence.
- R3: The size code selects the operand width: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An operand whose address is a multiple of its size uses one read beat and one write beat. Any other operand uses two of each. The first beat carries the bytes below the next multiple of the size, and the second beat carries the rest. Each beat's address is the 8-byte-aligned address of its bytes, and `bus_be` bit j enables byte j of that 8-byte word.
- R4: `bus_lock` rises before the first read beat and stays high through the last write beat without a gap. All read beats come before all write beats, and no locked beat is issued without the lock.
- R5: The second requester's kind codes are 0 load, 1 store, 2 instruction fetch and 3 page walk. Kinds 2 and 3 are granted in any state, including while the lock is held, and they win over the sequencer's own beats.
- R6: A kind 0 or 1 request is never granted while `bus_lock` is high. It is granted again in the cycle the lock drops.
- R7: Operation code 0 (exchange) writes the low size bytes of the operand in little-endian order.
- R8: Operation code 1 (add) writes the old value plus the operand, taken modulo 2 to the power of 8 times the size.
- R9: `done` pulses for exactly one cycle, in the cycle after the last write beat, with `bus_lock` already low. `done_old` then carries the old operand value, zero-extended.
- R10: A bypass read granted during the lock does not change the old value that the sequencer captured or the value it writes.
- R11: A beat presented while `bus_ready` is low is held and presented again, so it is neither lost nor repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Locked request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size code (0..3 = 1..8 bytes) |
| req_op | input | 1 | 0 exchange, 1 add |
| req_operand | input | 64 | Operand value, low bytes used |
| done | output | 1 | Completion pulse |
| done_old | output | 64 | Previous operand value |
| slot_busy | input | N_SLOTS | Earlier memory operations still in flight |
| slot_wc_load | input | N_SLOTS | Slot holds a write-combining load |
| oth_req | input | 1 | Second requester wants the bus |
| oth_kind | input | 2 | Second requester kind (0 load, 1 store, 2 fetch, 3 walk) |
| oth_addr | input | ADDR_W | Second requester address |
| oth_we | input | 1 | Second requester write |
| oth_be | input | 8 | Second requester byte enables |
| oth_wdata | input | 64 | Second requester write data |
| oth_gnt | output | 1 | Second requester owns the bus this cycle |
| bus_valid | output | 1 | Bus transaction presented |
| bus_ready | input | 1 | Bus accepts the transaction this cycle |
| bus_we | output | 1 | Bus write |
| bus_addr | output | ADDR_W | Bus address (8-byte aligned for locked beats) |
| bus_be | output | 8 | Bus byte enables |
| bus_wdata | output | 64 | Bus write data |
| bus_lock | output | 1 | Bus lock |
| bus_rdata | input | 64 | Bus read data, valid with bus_ready |

## Verification
The bench runs every size at every byte offset within an 8-byte word, with both operations, over a byte-addressed memory model. For each case it checks the beat count, the byte enables and the addresses against a per-byte calculation. A design that split only at 8-byte boundaries, or put a byte in the wrong beat, would fail here or corrupt neighbouring bytes. Half of the runs hold `bus_ready` low now and then, which shows up a beat that is dropped or issued twice. The directed cases cover the rest:
- A strongly ordered slot is held busy, and the bench watches for the lock rising too early. A write-combining-only slot is also busy, and the bench watches for the sequence waiting on it needlessly.
- Fetch and walk requests arrive mid-lock. A design that refused them would deadlock, and one that overwrote its capture register would return the wrong value.
- A data load is held during the lock and must not be granted until the lock drops.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

    localparam int BUS_BYTES = 8;
    localparam int BUS_W     = BUS_BYTES * 8;
    localparam int WIN_BYTES = 2 * BUS_BYTES;
    localparam int WIN_W     = WIN_BYTES * 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_READ    = 3'd2,
        ST_MODIFY  = 3'd3,
        ST_WRITE   = 3'd4,
        ST_RELEASE = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_FETCH = 2'd2,
        K_WALK  = 2'd3
    } xfer_kind_e;

    // Mask keeping the low bytes of an operand of the given size code.
    function automatic logic [BUS_W-1:0] width_mask(input logic [1:0] sz);
        logic [BUS_W-1:0] m;
        case (sz)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/atom_split.sv
// Splits an operand into one or two beats at the next multiple of its size.
module atom_split
    import atomic_pkg::*;
(
    input  logic [2:0]           off,
    input  logic [1:0]           sz,
    output logic                 two_beat,
    output logic                 beat1_next_qw,
    output logic [BUS_BYTES-1:0] be0,
    output logic [BUS_BYTES-1:0] be1
);
    localparam int MW = 2 * BUS_BYTES;

    logic [3:0]    nbytes;
    logic [3:0]    bound;
    logic [MW-1:0] full;
    logic [MW-1:0] lo_mask;
    logic [MW-1:0] lo_part;
    logic [MW-1:0] hi_part;

    always_comb begin
        nbytes  = 4'd1 << sz;
        full    = ((MW'(1) << nbytes) - MW'(1)) << off;
        bound   = ({1'b0, off} & ~(nbytes - 4'd1)) + nbytes;
        lo_mask = (MW'(1) << bound) - MW'(1);
        lo_part = full & lo_mask;
        hi_part = full & ~lo_mask;
        two_beat      = |hi_part;
        beat1_next_qw = |hi_part[MW-1:BUS_BYTES];
        be0 = lo_part[BUS_BYTES-1:0];
        be1 = hi_part[MW-1:BUS_BYTES] | hi_part[BUS_BYTES-1:0];
    end
endmodule

// File: rtl/atom_alu.sv
// Computes the value written back: the operand or the sum, cut to the size.
module atom_alu
    import atomic_pkg::*;
(
    input  logic [BUS_W-1:0] old_val,
    input  logic [BUS_W-1:0] operand,
    input  logic [1:0]       sz,
    input  logic             is_add,
    output logic [BUS_W-1:0] new_val
);
    logic [BUS_W-1:0] sum;

    always_comb begin
        sum     = old_val + operand;
        new_val = (is_add ? sum : operand) & width_mask(sz);
    end
endmodule

// File: rtl/atom_arb.sv
// Bus arbitration between the locked engine and the second requester.
module atom_arb
    import atomic_pkg::*;
(
    input  logic       data_ok,
    input  logic       eng_req,
    input  logic       oth_req,
    input  logic [1:0] oth_kind,
    output logic       oth_gnt,
    output logic       eng_gnt
);
    logic bypass_kind;

    always_comb begin
        bypass_kind = (oth_kind == K_FETCH) || (oth_kind == K_WALK);
        oth_gnt     = oth_req && (bypass_kind || data_ok);
        eng_gnt     = eng_req && !oth_gnt;
    end
endmodule

// File: rtl/atomic_lock_seq.sv
module atomic_lock_seq
    import atomic_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int N_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_op,
    input  logic [63:0]       req_operand,
    output logic              done,
    output logic [63:0]       done_old,
    input  logic [N_SLOTS-1:0] slot_busy,
    input  logic [N_SLOTS-1:0] slot_wc_load,
    input  logic              oth_req,
    input  logic [1:0]        oth_kind,
    input  logic [ADDR_W-1:0] oth_addr,
    input  logic              oth_we,
    input  logic [7:0]        oth_be,
    input  logic [63:0]       oth_wdata,
    output logic              oth_gnt,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_be,
    output logic [63:0]       bus_wdata,
    output logic              bus_lock,
    input  logic [63:0]       bus_rdata
);
    localparam int OFF_W = $clog2(BUS_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic              beat;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        sz;
        logic              is_add;
        logic [BUS_W-1:0]  opnd;
        logic [WIN_W-1:0]  win;
        logic [BUS_W-1:0]  old;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic                 two_beat;
    logic                 sp_next;
    logic [BUS_BYTES-1:0] be0, be1;
    logic                 drain_block;
    logic                 eng_req, eng_gnt, data_ok;
    logic [ADDR_W-1:0]    qw0_addr, qw1_addr;
    logic [5:0]           shamt;
    logic [WIN_W-1:0]     win_shift;
    logic [BUS_W-1:0]     old_val, alu_new;
    logic [WIN_W-1:0]     new_win;
    logic [WIN_W-1:0]     cap_win;
    logic                 beat_xfer;
    logic                 last_beat;

    atom_split u_split (
        .off           (r_q.addr[OFF_W-1:0]),
        .sz            (r_q.sz),
        .two_beat      (two_beat),
        .beat1_next_qw (sp_next),
        .be0           (be0),
        .be1           (be1)
    );

    atom_alu u_alu (
        .old_val (old_val),
        .operand (r_q.opnd),
        .sz      (r_q.sz),
        .is_add  (r_q.is_add),
        .new_val (alu_new)
    );

    atom_arb u_arb (
        .data_ok  (data_ok),
        .eng_req  (eng_req),
        .oth_req  (oth_req),
        .oth_kind (oth_kind),
        .oth_gnt  (oth_gnt),
        .eng_gnt  (eng_gnt)
    );

    // Byte-lane capture into the two-word window; lanes 0..7 hold the first
    // word touched, lanes 8..15 the following word.
    for (genvar j = 0; j < WIN_BYTES; j++) begin : g_lane
        localparam int QW = j / BUS_BYTES;
        localparam int LB = j % BUS_BYTES;
        logic hit;
        assign hit = r_q.beat ? (((QW == 1) == sp_next) && be1[LB])
                              : ((QW == 0) && be0[LB]);
        assign cap_win[j*8 +: 8] = hit ? bus_rdata[LB*8 +: 8] : r_q.win[j*8 +: 8];
    end

    always_comb begin
        drain_block = |(slot_busy & ~slot_wc_load);
        eng_req     = (r_q.st == ST_READ) || (r_q.st == ST_WRITE);
        data_ok     = (r_q.st == ST_IDLE) || (r_q.st == ST_RELEASE);
        qw0_addr    = {r_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        qw1_addr    = qw0_addr + (sp_next ? ADDR_W'(BUS_BYTES) : '0);
        shamt       = {r_q.addr[OFF_W-1:0], 3'b000};
        win_shift   = r_q.win >> shamt;
        old_val     = win_shift[BUS_W-1:0] & width_mask(r_q.sz);
        new_win     = {{BUS_W{1'b0}}, alu_new} << shamt;
        beat_xfer   = eng_gnt && bus_ready;
        last_beat   = r_q.beat || !two_beat;
    end

    // Next-state computation.
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_DRAIN;
                    r_d.addr   = req_addr;
                    r_d.sz     = req_size;
                    r_d.is_add = req_op;
                    r_d.opnd   = req_operand;
                    r_d.beat   = 1'b0;
                    r_d.win    = '0;
                end
            end
            ST_DRAIN: begin
                if (!drain_block) begin
                    r_d.st   = ST_READ;
                    r_d.beat = 1'b0;
                end
            end
            ST_READ: begin
                if (beat_xfer) begin
                    r_d.win = cap_win;
                    if (last_beat) begin
                        r_d.beat = 1'b0;
                        r_d.st   = ST_MODIFY;
                    end else begin
                        r_d.beat = 1'b1;
                    end
                end
            end
            ST_MODIFY: begin
                r_d.old = old_val;
                r_d.win = new_win;
                r_d.st  = ST_WRITE;
            end
            ST_WRITE: begin
                if (beat_xfer) begin
                    if (last_beat) begin
                        r_d.beat = 1'b0;
                        r_d.st   = ST_RELEASE;
                    end else begin
                        r_d.beat = 1'b1;
                    end
                end
            end
            ST_RELEASE: r_d.st = ST_IDLE;
            default:    r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Outputs and bus steering.
    always_comb begin
        req_ready = (r_q.st == ST_IDLE);
        done      = (r_q.st == ST_RELEASE);
        done_old  = r_q.old;
        bus_lock  = (r_q.st == ST_READ) || (r_q.st == ST_MODIFY) || (r_q.st == ST_WRITE);
        bus_valid = oth_gnt || eng_gnt;
        if (oth_gnt) begin
            bus_we    = oth_we;
            bus_addr  = oth_addr;
            bus_be    = oth_be;
            bus_wdata = oth_wdata;
        end else if (eng_gnt) begin
            bus_we    = (r_q.st == ST_WRITE);
            bus_addr  = r_q.beat ? qw1_addr : qw0_addr;
            bus_be    = r_q.beat ? be1 : be0;
            bus_wdata = (r_q.beat && sp_next) ? r_q.win[WIN_W-1:BUS_W] : r_q.win[BUS_W-1:0];
        end else begin
            bus_we    = 1'b0;
            bus_addr  = '0;
            bus_be    = '0;
            bus_wdata = '0;
        end
    end
endmodule

// File: rtl/atomic_lock_seq_chk.sv
module atomic_lock_seq_chk #(
    parameter int N_SLOTS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               bus_lock,
    input logic               req_ready,
    input logic               oth_gnt,
    input logic [1:0]         oth_kind,
    input logic               eng_gnt,
    input logic [7:0]         bus_be,
    input logic [N_SLOTS-1:0] slot_busy,
    input logic [N_SLOTS-1:0] slot_wc_load
);
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> !req_ready);

    a_r2_drained_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> $past((slot_busy & ~slot_wc_load) == '0));

    a_r3_beat_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        eng_gnt |-> (bus_be != 8'd0));

    a_r4_lock_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> done);

    a_r5_bypass_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && oth_gnt) |-> oth_kind[1]);

    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_gnt, oth_gnt}));

    a_r6_data_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (oth_gnt && !oth_kind[1]) |-> !bus_lock);

    a_r9_done_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_lock);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind atomic_lock_seq atomic_lock_seq_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .bus_lock     (bus_lock),
    .req_ready    (req_ready),
    .oth_gnt      (oth_gnt),
    .oth_kind     (oth_kind),
    .eng_gnt      (eng_gnt),
    .bus_be       (bus_be),
    .slot_busy    (slot_busy),
    .slot_wc_load (slot_wc_load)
);

// File: tb/atomic_lock_seq_tb.sv
module atomic_lock_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_op;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_operand;
    logic        done;
    logic [63:0] done_old;
    logic [3:0]  slot_busy, slot_wc_load;
    logic        oth_req, oth_we, oth_gnt;
    logic [1:0]  oth_kind;
    logic [31:0] oth_addr;
    logic [7:0]  oth_be;
    logic [63:0] oth_wdata;
    logic        bus_valid, bus_ready, bus_we, bus_lock;
    logic [31:0] bus_addr;
    logic [7:0]  bus_be;
    logic [63:0] bus_wdata, bus_rdata;

    atomic_lock_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_op(req_op), .req_operand(req_operand),
        .done(done), .done_old(done_old),
        .slot_busy(slot_busy), .slot_wc_load(slot_wc_load),
        .oth_req(oth_req), .oth_kind(oth_kind), .oth_addr(oth_addr),
        .oth_we(oth_we), .oth_be(oth_be), .oth_wdata(oth_wdata), .oth_gnt(oth_gnt),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_lock(bus_lock), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    logic [7:0] mem     [0:63];
    logic [7:0] exp_mem [0:63];
    int total = 0, bad = 0, cyc = 0;
    int rdy_mode = 0;
    int n_rd, n_wr, order_err, unlocked, gap, bad_grant;
    logic [7:0]  rd_be [0:1], wr_be [0:1];
    logic [31:0] rd_ad [0:1], wr_ad [0:1];
    logic        lock_prev = 1'b0;
    logic [63:0] exp_old;
    logic [7:0]  exp_be0, exp_be1;
    logic [31:0] exp_ad0, exp_ad1;
    int          exp_beats;
    bit          cur_add;

    always_comb begin
        for (int k = 0; k < 8; k++) bus_rdata[k*8 +: 8] = mem[{bus_addr[5:3], 3'(k)}];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL R9 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Bus model and monitor, sampled 2 ns after the falling edge.
    always @(negedge clk) begin
        bus_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
        #2;
        if (bus_valid && bus_ready) begin
            if (!oth_gnt) begin
                if (!bus_lock) unlocked++;
                if (!bus_we) begin
                    if (n_rd < 2) begin rd_be[n_rd] = bus_be; rd_ad[n_rd] = bus_addr; end
                    if (n_wr > 0) order_err++;
                    n_rd++;
                end else begin
                    if (n_wr < 2) begin wr_be[n_wr] = bus_be; wr_ad[n_wr] = bus_addr; end
                    n_wr++;
                end
            end
            if (bus_we)
                for (int k = 0; k < 8; k++)
                    if (bus_be[k]) mem[{bus_addr[5:3], 3'(k)}] = bus_wdata[k*8 +: 8];
        end
        if (lock_prev && !bus_lock && !done) gap++;
        if (bus_lock && oth_gnt && !oth_kind[1]) bad_grant++;
        lock_prev = bus_lock;
    end

    // Preload memory, compute expectations, present one request.
    task automatic issue(input int a, input int sz, input bit add, input logic [63:0] opnd, input int seed);
        int s, bnd;
        logic [63:0] nv, m;
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'(i * 37 + seed * 11 + 5);
            exp_mem[i] = mem[i];
        end
        s = 1 << sz;
        exp_old = '0;
        for (int k = 0; k < s; k++) exp_old[k*8 +: 8] = mem[a + k];
        m  = (sz == 3) ? '1 : ((64'd1 << (8 * s)) - 64'd1);
        nv = (add ? exp_old + opnd : opnd) & m;
        for (int k = 0; k < s; k++) exp_mem[a + k] = nv[k*8 +: 8];
        bnd = (a / s) * s + s;
        exp_be0 = '0; exp_be1 = '0;
        for (int k = 0; k < s; k++) begin
            if (a + k < bnd) exp_be0[(a + k) % 8] = 1'b1;
            else             exp_be1[(a + k) % 8] = 1'b1;
        end
        exp_ad0   = 32'(a & ~7);
        exp_ad1   = 32'((a + s - 1) & ~7);
        exp_beats = ((a % s) == 0) ? 1 : 2;
        cur_add   = add;
        n_rd = 0; n_wr = 0; order_err = 0; unlocked = 0; gap = 0; bad_grant = 0;
        req_addr = 32'(a); req_size = 2'(sz); req_op = add; req_operand = opnd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #3;
            if (done) break;
        end
    endtask

    task automatic check_result();
        int mism = 0;
        bit be_ok;
        chk(done === 1'b1, "R9 done seen", 64'(done), 64'd1);
        chk(done_old === exp_old, cur_add ? "R8 old value" : "R7 old value", done_old, exp_old);
        for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk(mism == 0, cur_add ? "R8 memory image" : "R7 memory image", 64'(mism), 64'd0);
        chk(n_rd == exp_beats && n_wr == exp_beats, (rdy_mode != 0) ? "R11 beat count" : "R3 beat count",
            64'(n_rd * 16 + n_wr), 64'(exp_beats * 17));
        be_ok = (rd_be[0] == exp_be0) && (wr_be[0] == exp_be0) &&
                (rd_ad[0] == exp_ad0) && (wr_ad[0] == exp_ad0);
        if (exp_beats == 2)
            be_ok = be_ok && (rd_be[1] == exp_be1) && (wr_be[1] == exp_be1) &&
                    (rd_ad[1] == exp_ad1) && (wr_ad[1] == exp_ad1);
        chk(be_ok, "R3 lanes and addresses", {rd_be[0], rd_be[1], 16'h0, rd_ad[0]},
            {exp_be0, exp_be1, 16'h0, exp_ad0});
        chk(gap == 0 && unlocked == 0 && order_err == 0, "R4 lock span",
            64'(gap * 256 + unlocked * 16 + order_err), 64'd0);
        @(negedge clk);
        #3;
        chk(!done && req_ready, "R9 single pulse", {62'd0, done, req_ready}, 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_op = 1'b0;
        req_operand = '0; slot_busy = '0; slot_wc_load = '0; oth_req = 1'b0;
        oth_kind = 2'd0; oth_addr = '0; oth_we = 1'b0; oth_be = '0; oth_wdata = '0;
        bus_ready = 1'b1;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        chk(req_ready && !bus_lock && !done && !bus_valid, "R1 reset state",
            {60'd0, req_ready, bus_lock, done, bus_valid}, 64'h8);

        // Sweep every size, offset and operation.
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 8; off++)
                for (int op = 0; op < 2; op++) begin
                    rdy_mode = (off + op) % 2;
                    issue(16 + off, sz, op[0], 64'hF0E1_D2C3_B4A5_9687 ^ 64'(off * 64'h0101_0101_0101_0101),
                          sz * 16 + off * 2 + op);
                    wait_done();
                    check_result();
                end
        rdy_mode = 0;

        // Drain: a strongly ordered slot blocks the start.
        slot_busy = 4'b0100; slot_wc_load = 4'b0000;
        issue(21, 2, 1'b1, 64'h1234_5678, 7);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #3;
            chk(!bus_lock && n_rd == 0, "R2 held while drain pending", {63'd0, bus_lock}, 64'd0);
            chk(!req_ready, "R1 busy during drain", 64'(req_ready), 64'd0);
        end
        slot_busy = 4'b0000;
        wait_done();
        check_result();

        // Drain: a write-combining load does not block.
        slot_busy = 4'b0011; slot_wc_load = 4'b0011;
        issue(19, 3, 1'b0, 64'hCAFE_F00D_DEAD_BEEF, 9);
        repeat (4) @(negedge clk);
        #3;
        chk(n_rd >= 1, "R2 WC load not waited on", 64'(n_rd), 64'd1);
        wait_done();
        check_result();
        slot_busy = '0; slot_wc_load = '0;

        // Bypass traffic in the middle of a locked split operation.
        issue(29, 3, 1'b1, 64'h0000_0001_0000_FFFF, 12);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bus_lock) break;
        end
        for (int i = 0; i < 3; i++) begin
            oth_req = 1'b1; oth_kind = (i == 1) ? 2'd3 : 2'd2; oth_addr = 32'd0;
            #3;
            chk(oth_gnt && bus_lock, "R5 bypass granted under lock", {62'd0, oth_gnt, bus_lock}, 64'd3);
            @(negedge clk);
        end
        oth_req = 1'b0;
        wait_done();
        check_result();
        chk(done_old === exp_old, "R10 capture untouched by bypass", done_old, exp_old);

        // Ordinary data load requested while the lock is held.
        issue(14, 1, 1'b0, 64'hABCD, 3);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bus_lock) break;
        end
        oth_req = 1'b1; oth_kind = 2'd0; oth_addr = 32'd8;
        for (int i = 0; i < 300; i++) begin
            #3;
            if (done) break;
            chk(!oth_gnt, "R6 data stalled under lock", 64'(oth_gnt), 64'd0);
            @(negedge clk);
        end
        chk(done && oth_gnt, "R6 data granted at release", {62'd0, done, oth_gnt}, 64'd3);
        chk(bad_grant == 0, "R6 no data grant under lock", 64'(bad_grant), 64'd0);
        @(negedge clk);
        oth_req = 1'b0;

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule